// File: doc/BRIEF.md
# Selected-Lane Quiet Detector

This block picks one of several single-bit serial lines with a small select code and passes that line straight through as its data output. In parallel it watches the chosen line for transitions and drives an active-high quiet flag when the line has stopped toggling. Any change of level counts as activity, whether it comes from real data or from noise. The flag clears again once the line shows activity again.

Timing is kept coarse. A free-running prescaler cuts time into windows of `TICK_CYCLES` system clocks. A tick boundary is a clock edge at which the number of clocks since reset release is a whole multiple of `TICK_CYCLES`. The flag only changes at these boundaries, and it reports the window that has just closed. The line is sampled through a two-stage synchronizer. With the default of 500 clocks at 100 MHz, one window lasts 5 us. The flag therefore rises between 5 us and 10 us after the last edge, and it falls at most 5 us after an edge.

When the select code changes, the block forgets everything it knew about the previous line. A level difference between the old line and the new one is not taken as an edge. The partial window that follows the change leaves the flag unchanged.

Top module: `lane_los_monitor`

## Requirements
- R1: `data_o` equals `lanes_i[sel_i]` in the same cycle, also during reset. Select code 0 routes lane 0, 1 routes lane 1, 2 routes lane 2 and 3 routes lane 3.
- R2: While `rst` is high and after it is released, `los_o` reads 1. It stays 1 until a tick boundary reports activity.
- R3: Any level change on the selected lane counts as activity, including a pulse only one clock wide.
- R4: An input change made at least 3 clocks before a tick boundary is counted in the window that ends at that boundary. It clears `los_o` at that boundary.
- R5: `los_o` rises at the first tick boundary that closes a complete window with no activity. This is one to two tick periods after the last edge.
- R6: Activity on lanes that are not selected has no effect on `los_o`.
- R7: `los_o` changes only at tick boundaries, or when reset is applied.
- R8: A change of `sel_i` discards activity already recorded and the quiet count. A level difference between the old and new lane is not activity. The first tick boundary after the change leaves `los_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lanes_i | input | NUM_LANES | Serial input lines, one bit per lane |
| sel_i | input | SEL_W | Lane select code |
| data_o | output | 1 | Selected lane, combinational |
| los_o | output | 1 | Quiet flag, active high |

## Verification
The bench places a single-clock glitch on the selected lane. A detector that needed two matching samples, or that filtered narrow pulses, would miss it and keep the flag high. It switches between lanes that sit at different static levels. A design without history clearing would take that level step as an edge and drop the flag, and a design that evaluated the partial window at once would raise the flag early. It also records activity just before a select change and toggles unselected lanes. A design that kept stale activity, or that watched the wrong lane, would clear the flag when it should not. The bench samples the flag one clock before and one clock after each boundary, so an assertion or release that came a window early or late shows up.

// File: rtl/los_pkg.sv
package los_pkg;

  // Width of a counter that must hold values 0..n-1 (at least one bit).
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Increment that wraps to zero after period-1.
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned period);
    return (v + 1 >= period) ? 0 : v + 1;
  endfunction

  // Increment that stops at lim.
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // True when a quiet count has reached the assertion threshold.
  function automatic bit quiet_reached(int unsigned v, int unsigned lim);
    return v >= lim;
  endfunction

endpackage

// File: rtl/los_tick_gen.sv
module los_tick_gen
  import los_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 500
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);

  localparam int unsigned CW = cnt_width(TICK_CYCLES);

  logic [CW-1:0] presc_q;

  assign tick_o = (presc_q == CW'(TICK_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
    end else begin
      presc_q <= CW'(wrap_inc(32'(presc_q), TICK_CYCLES));
    end
  end

endmodule

// File: rtl/los_lane_front.sv
module los_lane_front
  import los_pkg::*;
#(
  parameter int unsigned NUM_LANES   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_LANES-1:0]          lanes_i,
  input  logic [cnt_width(NUM_LANES)-1:0] sel_i,
  output logic                          data_o,
  output logic                          edge_o,
  output logic                          sel_chg_o
);

  localparam int unsigned SEL_W = cnt_width(NUM_LANES);
  localparam int unsigned FW    = cnt_width(SYNC_STAGES + 1);

  logic             lane_data;
  logic [SEL_W-1:0] sel_q;
  logic [SYNC_STAGES:0] pipe_q;
  logic [FW-1:0]    fill_q;
  logic             fill_full;

  // Lane multiplexer.
  always_comb begin
    lane_data = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (sel_i == SEL_W'(i)) lane_data = lanes_i[i];
    end
  end

  assign data_o    = lane_data;
  assign sel_chg_o = (sel_i != sel_q);

  always_ff @(posedge clk) begin
    sel_q <= sel_i;
  end

  // Synchronizer chain plus one history stage; no reset so that the
  // current lane level is shifted in during reset.
  always_ff @(posedge clk) begin
    pipe_q[0] <= lane_data;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_pipe
    always_ff @(posedge clk) begin
      pipe_q[g] <= pipe_q[g-1];
    end
  end

  // History fill: edges only count once both compared stages hold
  // samples taken from the current lane.
  assign fill_full = (fill_q == FW'(SYNC_STAGES));

  always_ff @(posedge clk) begin
    if (rst || sel_chg_o) begin
      fill_q <= '0;
    end else if (!fill_full) begin
      fill_q <= FW'(sat_inc(32'(fill_q), SYNC_STAGES));
    end
  end

  assign edge_o = fill_full && (pipe_q[SYNC_STAGES-1] != pipe_q[SYNC_STAGES]);

endmodule

// File: rtl/los_quiet_eval.sv
module los_quiet_eval
  import los_pkg::*;
#(
  parameter int unsigned QUIET_WINDOWS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic edge_i,
  input  logic sel_chg_i,
  output logic seen_o,
  output logic partial_o,
  output logic los_o
);

  localparam int unsigned QW = cnt_width(QUIET_WINDOWS + 1);

  logic          act_q;
  logic          partial_q;
  logic          los_q;
  logic [QW-1:0] quiet_q;
  logic [QW-1:0] quiet_nxt;

  assign seen_o    = act_q | edge_i;
  assign partial_o = partial_q;
  assign los_o     = los_q;
  assign quiet_nxt = QW'(sat_inc(32'(quiet_q), QUIET_WINDOWS));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      partial_q <= 1'b0;
      quiet_q   <= '0;
      los_q     <= 1'b1;
    end else if (sel_chg_i) begin
      act_q     <= 1'b0;
      partial_q <= 1'b1;
      quiet_q   <= '0;
    end else if (tick_i) begin
      act_q <= 1'b0;
      if (seen_o) begin
        quiet_q   <= '0;
        partial_q <= 1'b0;
        los_q     <= 1'b0;
      end else if (partial_q) begin
        partial_q <= 1'b0;
      end else begin
        quiet_q <= quiet_nxt;
        if (quiet_reached(32'(quiet_nxt), QUIET_WINDOWS)) los_q <= 1'b1;
      end
    end else if (edge_i) begin
      act_q <= 1'b1;
    end
  end

endmodule

// File: rtl/lane_los_monitor.sv
module lane_los_monitor
  import los_pkg::*;
#(
  parameter int unsigned NUM_LANES     = 4,
  parameter int unsigned TICK_CYCLES   = 500,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned QUIET_WINDOWS = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_LANES-1:0]            lanes_i,
  input  logic [cnt_width(NUM_LANES)-1:0] sel_i,
  output logic                            data_o,
  output logic                            los_o
);

  logic tick_w;
  logic edge_w;
  logic sel_chg_w;
  logic seen_w;
  logic partial_w;

  los_tick_gen #(
    .TICK_CYCLES(TICK_CYCLES)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick_w)
  );

  los_lane_front #(
    .NUM_LANES   (NUM_LANES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_front (
    .clk       (clk),
    .rst       (rst),
    .lanes_i   (lanes_i),
    .sel_i     (sel_i),
    .data_o    (data_o),
    .edge_o    (edge_w),
    .sel_chg_o (sel_chg_w)
  );

  los_quiet_eval #(
    .QUIET_WINDOWS(QUIET_WINDOWS)
  ) u_eval (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_w),
    .edge_i    (edge_w),
    .sel_chg_i (sel_chg_w),
    .seen_o    (seen_w),
    .partial_o (partial_w),
    .los_o     (los_o)
  );

endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
  input logic clk,
  input logic rst,
  input logic tick_w,
  input logic edge_w,
  input logic sel_chg_w,
  input logic seen_w,
  input logic partial_w,
  input logic los_o
);

  // R2: reset forces the flag high
  p_reset_high_r2: assert property (@(posedge clk) rst |=> los_o);

  // R4: a reported window with activity clears the flag
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_w && seen_w && !sel_chg_w) |=> !los_o);

  // R5: the flag only rises after a tick with no activity, outside a partial window
  p_rise_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(los_o)) |-> $past(tick_w && !seen_w && !partial_w));

  // R5: an edge in this cycle blocks a rise in the next
  p_edge_blocks_rise_r5: assert property (@(posedge clk) disable iff (rst)
    edge_w |=> !$rose(los_o));

  // R7: flag changes only at tick boundaries
  p_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(los_o)) |-> $past(tick_w));

  // R8: select change holds the flag and hides the level step
  p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
    sel_chg_w |=> $stable(los_o));

  p_sel_no_edge_r8: assert property (@(posedge clk) disable iff (rst)
    sel_chg_w |=> !edge_w);

endmodule

bind lane_los_monitor los_monitor_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_w    (tick_w),
  .edge_w    (edge_w),
  .sel_chg_w (sel_chg_w),
  .seen_w    (seen_w),
  .partial_w (partial_w),
  .los_o     (los_o)
);

// File: tb/lane_los_monitor_tb.sv
`timescale 1ns/1ps
module lane_los_monitor_tb;

  localparam int T = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] lanes = 4'b0000;
  logic [1:0] sel = 2'b00;
  logic       data_o;
  logic       los_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  lane_los_monitor #(
    .NUM_LANES(4), .TICK_CYCLES(T), .SYNC_STAGES(2), .QUIET_WINDOWS(1)
  ) u_dut (
    .clk(clk), .rst(rst), .lanes_i(lanes), .sel_i(sel),
    .data_o(data_o), .los_o(los_o)
  );

  // {sel, lanes, expected data}
  localparam logic [6:0] MUX_VEC [8] = '{
    {2'b00, 4'b0001, 1'b1}, {2'b01, 4'b0001, 1'b0},
    {2'b01, 4'b0010, 1'b1}, {2'b10, 4'b1011, 1'b0},
    {2'b10, 4'b0100, 1'b1}, {2'b11, 4'b0111, 1'b0},
    {2'b11, 4'b1000, 1'b1}, {2'b00, 4'b1110, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cyc %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic wait_to(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1: mux table walked during reset
    repeat (2) @(negedge clk);
    chk("R2 los in reset", los_o, 1'b1);
    for (int i = 0; i < 8; i++) begin
      sel   = MUX_VEC[i][6:5];
      lanes = MUX_VEC[i][4:1];
      #1;
      chk("R1 mux", data_o, MUX_VEC[i][0]);
      @(negedge clk);
    end
    lanes = 4'b0000;
    sel   = 2'b00;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    wait_to(T + 2);         chk("R2 quiet after reset", los_o, 1'b1);
    wait_to(T + 5);         lanes[0] = ~lanes[0];
    wait_to(2*T - 1);       chk("R7 no change before tick", los_o, 1'b1);
    wait_to(2*T + 1);       chk("R4 release at tick", los_o, 1'b0);
    wait_to(2*T + 5);       lanes[0] = ~lanes[0];
    wait_to(3*T + 1);       chk("R3 activity keeps low", los_o, 1'b0);
    wait_to(3*T + 5);       lanes[0] = ~lanes[0];
    wait_to(4*T + 1);       chk("R3 activity keeps low", los_o, 1'b0);
    wait_to(4*T + 5);       lanes[0] = ~lanes[0];
    wait_to(5*T + 1);       chk("R5 tick after last edge stays low", los_o, 1'b0);
    wait_to(6*T - 1);       chk("R5 low through quiet window", los_o, 1'b0);
    wait_to(6*T + 1);       chk("R5 assert after full quiet window", los_o, 1'b1);

    // R6: unselected lane activity
    for (int k = 6*T + 5; k <= 10*T - 5; k += 5) begin
      wait_to(k);
      lanes[1] = ~lanes[1];
      if (k == 6*T + 10) lanes[2] = 1'b1;
      if (k == 7*T + 5 || k == 9*T + 5) chk("R6 other lane ignored", los_o, 1'b1);
    end
    wait_to(10*T + 1);      chk("R6 other lane ignored", los_o, 1'b1);

    // R3: single-clock glitch
    wait_to(10*T + 5);      lanes[0] = 1'b1;
    wait_to(10*T + 6);      lanes[0] = 1'b0;
    wait_to(11*T - 1);      chk("R3 glitch before tick", los_o, 1'b1);
    wait_to(11*T + 1);      chk("R3 glitch counts", los_o, 1'b0);

    // R8: switch to quiet lane 2 (level 1) while low
    wait_to(11*T + 5);      sel = 2'b10;
    wait_to(12*T + 1);      chk("R8 partial window holds", los_o, 1'b0);
    wait_to(13*T - 1);      chk("R8 low before full window", los_o, 1'b0);
    wait_to(13*T + 1);      chk("R8 assert after full window", los_o, 1'b1);

    // R8: switch to lane 0 (level 0) while high: level step is not an edge
    wait_to(13*T + 5);      sel = 2'b00;
    wait_to(14*T + 1);      chk("R8 level step not activity", los_o, 1'b1);
    wait_to(15*T + 1);      chk("R8 stays high", los_o, 1'b1);

    // R8: pending activity discarded by select change
    wait_to(15*T + 5);      lanes[0] = ~lanes[0];
    wait_to(15*T + 10);     sel = 2'b01;
    wait_to(16*T + 1);      chk("R8 stale activity dropped", los_o, 1'b1);
    wait_to(16*T + 10);     lanes[1] = ~lanes[1];
    wait_to(17*T + 1);      chk("R4 new lane release", los_o, 1'b0);
    #1;                     chk("R1 mux lane1", data_o, lanes[1]);

    // R2: mid-run reset
    wait_to(17*T + 5);      rst = 1'b1;
    @(negedge clk);         chk("R2 reset forces high", los_o, 1'b1);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wait_to(5);             chk("R2 high after reset", los_o, 1'b1);
    wait_to(T + 1);         chk("R5 high after quiet window", los_o, 1'b1);

    summary();
  end

endmodule